// File: doc/BRIEF.md
# Receive FIFO Burst Writer

This block moves read data for a storage read command from an internal staging buffer into an external receive FIFO. The transfer happens in bursts of 32 beats of 128 bits, which is 512 bytes per burst. A command starts with a one-cycle start pulse that carries the total length in 512-byte units. The block then issues as many bursts as the length asks for, and raises a one-cycle done pulse once the last beat has been written.

Before each burst the block checks two conditions. The first is free room in the external FIFO, judged from the FIFO's 16-bit write count. The second is that at least one full burst of data is already held in the staging buffer, judged from the buffer's occupancy count. If either condition fails, the block waits with no time limit and reports no error. The staging buffer has one cycle of read latency. The block therefore raises the buffer read enable one cycle ahead of each FIFO write, and passes the buffer's read data straight to the FIFO write data.

The controller is a state machine with five states:
- `ST_IDLE`: waits for start.
- `ST_CHECK`: decides whether to launch a burst or to finish.
- `ST_BURST`: 32 cycles of buffer reads.
- `ST_DRAIN`: one cycle in which the last FIFO write lands.
- `ST_FINISH`: the done pulse.

It has these transitions:
- `ST_IDLE` to `ST_CHECK` on start.
- `ST_CHECK` to `ST_FINISH` when no bursts remain.
- `ST_CHECK` to `ST_BURST` when bursts remain and both conditions hold.
- `ST_CHECK` stays in `ST_CHECK` otherwise.
- `ST_BURST` to `ST_DRAIN` on the 32nd read.
- `ST_DRAIN` to `ST_CHECK`.
- `ST_FINISH` to `ST_IDLE`.

Top module: `rxfifo_burst_writer`

## Requirements
- R1: A burst is launched only when the FIFO write count is below 0xFFC0, that is, when bits [15:6] of the count are not all ones. Counts narrower than 16 bits arrive padded with ones in the upper bits, so a value of 0xFFC0 or above means "no room".
- R2: A burst is launched only when the buffer occupancy count is at least 32 beats.
- R3: Each burst drives the FIFO write enable high for exactly 32 consecutive cycles. The buffer read enable is high in the cycle before every FIFO write. The FIFO write data is the buffer read data, in the order the beats were read.
- R4: Between two bursts the FIFO write enable stays low for at least one cycle.
- R5: A command of length N (N ≥ 0) produces exactly N bursts and then a single one-cycle done pulse. With both conditions true throughout, done is high 34·N+1 clock edges after the edge that samples start. For N = 0 this means done after 1 edge and no writes.
- R6: While a launch condition is false, the block holds the write enable low for as long as needed. It resumes the same command once the condition becomes true.
- R7: After reset, the FIFO write enable, the buffer read enable and done are all low.
- R8: A start pulse that arrives while a command is in progress is ignored. It changes neither the number of writes nor the time of done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle command start |
| len_i | input | 16 | Command length in 512-byte units, sampled with start |
| fifo_wr_cnt_i | input | 16 | Fill count of the external receive FIFO |
| fifo_wr_en_o | output | 1 | Receive FIFO write enable |
| fifo_wr_data_o | output | 128 | Receive FIFO write data |
| buf_avail_i | input | 16 | Beats currently held in the staging buffer |
| buf_rd_en_o | output | 1 | Staging buffer read enable |
| buf_rd_data_i | input | 128 | Staging buffer read data, valid one cycle after the read enable |
| done_o | output | 1 | One-cycle pulse when the command is complete |

## Verification
Each FIFO write is expected one cycle after its buffer read. The bench samples on the falling edge and keeps the read enable of the previous cycle to confirm that one-cycle lead. The done pulse is due 34·N+1 rising edges after the start edge. The bench counts edges from that start edge and compares the count with the exact number in each vector. For the blocked cases it holds a condition false for a fixed window, checks that no write and no done appear in that window, then releases the condition and checks the write total.

// File: rtl/rxfifo_burst_pkg.sv
package rxfifo_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_BURST,
        ST_DRAIN,
        ST_FINISH
    } rxfb_state_e;
endpackage

// File: rtl/rxfb_launch_gate.sv
module rxfb_launch_gate #(
    parameter int CNT_W   = 16,
    parameter int AVAIL_W = 16,
    parameter int BEATS   = 32
) (
    input  logic [CNT_W-1:0]   fifo_cnt_i,
    input  logic [AVAIL_W-1:0] avail_i,
    output logic               go_o
);
    // Room exists while the count stays below the band of the top 2*BEATS values
    localparam longint SPAN     = 2 * BEATS;
    localparam longint BLOCK_LL = (longint'(1) << CNT_W) - SPAN;
    localparam logic [CNT_W-1:0]   BLOCK_AT  = CNT_W'(BLOCK_LL);
    localparam logic [AVAIL_W-1:0] NEED_DATA = AVAIL_W'(BEATS);

    logic space_ok;
    logic data_ok;

    always_comb begin
        space_ok = (fifo_cnt_i < BLOCK_AT);   // R1
        data_ok  = (avail_i >= NEED_DATA);    // R2
        go_o     = space_ok && data_ok;
    end
endmodule

// File: rtl/rxfifo_burst_writer.sv
module rxfifo_burst_writer
    import rxfifo_burst_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 16,
    parameter int AVAIL_W = 16,
    parameter int DATA_W  = 128,
    parameter int BEATS   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [CNT_W-1:0]   fifo_wr_cnt_i,
    output logic               fifo_wr_en_o,
    output logic [DATA_W-1:0]  fifo_wr_data_o,
    input  logic [AVAIL_W-1:0] buf_avail_i,
    output logic               buf_rd_en_o,
    input  logic [DATA_W-1:0]  buf_rd_data_i,
    output logic               done_o
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam int RUN_W = BEAT_W + 2;
    localparam longint BLOCK_LL = (longint'(1) << CNT_W) - 2 * BEATS;
    localparam logic [CNT_W-1:0] BLOCK_AT = CNT_W'(BLOCK_LL);

    rxfb_state_e      state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic [BEAT_W-1:0] beat_q;
    logic             wr_en_q;
    logic             go;

    rxfb_launch_gate #(
        .CNT_W  (CNT_W),
        .AVAIL_W(AVAIL_W),
        .BEATS  (BEATS)
    ) u_gate (
        .fifo_cnt_i(fifo_wr_cnt_i),
        .avail_i   (buf_avail_i),
        .go_o      (go)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (rem_q == '0)  state_d = ST_FINISH;
                else if (go)      state_d = ST_BURST;
            end
            ST_BURST:  if (beat_q == LAST_BEAT) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_CHECK;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            beat_q  <= '0;
            wr_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i)
                rem_q <= len_i;
            else if (state_q == ST_CHECK && rem_q != '0 && go)
                rem_q <= rem_q - 1'b1;
            beat_q  <= (state_q == ST_BURST) ? beat_q + 1'b1 : '0;
            wr_en_q <= (state_q == ST_BURST);   // write lands one cycle after the read
        end
    end

    // Outputs
    always_comb begin
        buf_rd_en_o    = (state_q == ST_BURST);
        done_o         = (state_q == ST_FINISH);
        fifo_wr_en_o   = wr_en_q;
        fifo_wr_data_o = buf_rd_data_i;
    end

    // Run-length tracker used by the burst-length assertion
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (fifo_wr_en_o) run_q <= run_q + 1'b1;
        else                   run_q <= '0;
    end

    p_space_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_rd_en_o) |-> $past(fifo_wr_cnt_i < BLOCK_AT));

    p_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_rd_en_o) |-> $past(buf_avail_i >= AVAIL_W'(BEATS)));

    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_wr_en_o) |-> (run_q == RUN_W'(BEATS)));

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_wr_en_o) |=> !fifo_wr_en_o);

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!fifo_wr_en_o && !buf_rd_en_o));
endmodule

// File: tb/rxfifo_burst_writer_bench.sv
`timescale 1ns/1ps
module rxfifo_burst_writer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  len = '0;
    logic [15:0]  fifo_cnt = 16'h0000;
    logic [15:0]  avail = 16'd64;
    logic         wr_en, rd_en, done;
    logic [127:0] wr_data;
    logic [127:0] rd_data = '0;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    rxfifo_burst_writer u_rxfifo_burst_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len),
        .fifo_wr_cnt_i(fifo_cnt), .fifo_wr_en_o(wr_en), .fifo_wr_data_o(wr_data),
        .buf_avail_i(avail), .buf_rd_en_o(rd_en), .buf_rd_data_i(rd_data),
        .done_o(done)
    );

    // Staging buffer model: one-cycle read latency, sequential content
    logic [31:0] rd_idx = '0;
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= {4{rd_idx}};
            rd_idx  <= rd_idx + 1;
        end
    end

    // Output monitor
    int  wr_total = 0;
    int  run = 0;
    int  mon_err = 0;
    logic [31:0] wr_idx = '0;
    logic prev_rd = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (wr_data !== {4{wr_idx}}) mon_err++;
                if (!prev_rd) mon_err++;
                wr_idx++;
                wr_total++;
                run++;
            end else begin
                if (run != 0 && run != 32) mon_err++;
                run = 0;
            end
            if (done && (wr_en || rd_en)) mon_err++;
        end
        prev_rd = rd_en;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pulse start, return edges until done and writes seen
    task automatic run_cmd(input logic [15:0] n, input int limit,
                           output int lat, output int writes);
        int w0;
        @(negedge clk);
        w0 = wr_total;
        start = 1'b1;
        len = n;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < limit) begin
            @(negedge clk);
            lat++;
        end
        writes = wr_total - w0;
    endtask

    localparam int NV = 5;
    localparam int V_LEN [NV] = '{1, 2, 3, 0, 5};
    localparam int V_LAT [NV] = '{35, 69, 103, 1, 171};
    localparam int V_WR  [NV] = '{32, 64, 96, 0, 160};

    initial begin
        int lat, writes, e0, w0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(!wr_en && !rd_en && !done, "R7 reset outputs", {wr_en, rd_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en && !rd_en && !done, "R7 idle after reset", {wr_en, rd_en, done}, 0);

        // Table walk: R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            fifo_cnt = (i % 2) ? 16'hFFBF : 16'h0010;
            avail    = (i % 2) ? 16'd32  : 16'd500;
            run_cmd(V_LEN[i][15:0], 1000, lat, writes);
            check(lat == V_LAT[i], "R5 done latency", lat, V_LAT[i]);
            check(writes == V_WR[i], "R5 write count", writes, V_WR[i]);
            check(mon_err == 0, "R3 R4 burst shape/order", mon_err, 0);
            @(negedge clk);
            check(!done, "R5 done one cycle", done, 0);
        end

        // R1 and R6: FIFO without room blocks the launch, then resumes
        fifo_cnt = 16'hFFC0;
        avail = 16'd100;
        @(negedge clk);
        w0 = wr_total;
        start = 1'b1; len = 16'd1;
        @(negedge clk);
        start = 1'b0;
        e0 = 0;
        repeat (200) begin
            @(negedge clk);
            if (done) e0++;
        end
        check(wr_total == w0, "R1 no write without room", wr_total - w0, 0);
        check(e0 == 0, "R6 no done while blocked", e0, 0);
        fifo_cnt = 16'hFFBF;
        lat = 0;
        while (!done && lat < 500) begin @(negedge clk); lat++; end
        check(done == 1'b1, "R6 resumes after room", done, 1);
        check(wr_total - w0 == 32, "R6 write count after resume", wr_total - w0, 32);

        // R2 and R6: buffer holding 31 beats blocks the launch
        fifo_cnt = 16'h0000;
        avail = 16'd31;
        @(negedge clk);
        w0 = wr_total;
        start = 1'b1; len = 16'd2;
        @(negedge clk);
        start = 1'b0;
        repeat (150) @(negedge clk);
        check(wr_total == w0, "R2 no write below 32 beats", wr_total - w0, 0);
        avail = 16'd32;
        lat = 0;
        while (!done && lat < 500) begin @(negedge clk); lat++; end
        check(wr_total - w0 == 64, "R2 writes after data arrives", wr_total - w0, 64);

        // R8: start pulse during an active command is ignored
        @(negedge clk);
        w0 = wr_total;
        start = 1'b1; len = 16'd2;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
            if (lat == 10) begin start = 1'b1; len = 16'd5; end
            if (lat == 11) start = 1'b0;
        end
        check(lat == 69, "R8 latency unchanged", lat, 69);
        check(wr_total - w0 == 64, "R8 write count unchanged", wr_total - w0, 64);
        repeat (200) @(negedge clk);
        check(wr_total - w0 == 64, "R8 no extra command", wr_total - w0, 64);
        check(mon_err == 0, "R3 R4 burst shape overall", mon_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule